// File: doc/BRIEF.md
# Predicate Mask Table

This block keeps up to sixteen predication entries and turns an operand reference into an element mask. Each entry names a target register, a register class (integer or floating-point), a predicate register, and the invert, zeroing and packed controls. When a lookup arrives with a register number, a class and an element count, the block finds the entry for that operand and reads the predicate register through a register-file read port. It then applies the invert control and returns the mask one cycle later, together with the zeroing and packed controls.

Entries are loaded through a configuration port in one of two encodings. The wide encoding is 16 bits and carries every field. The narrow encoding is 8 bits and has no predicate register field: the slot number picks the register instead, with slot k using x(9+k). The block does not search the stored entries. It keeps a reverse map, indexed by class and register number, that points at the owning slot, so a lookup is a single indexed read.

Top module: `predmask_table`

## Requirements
- R1: After reset, every entry is empty and `out_valid` is 0. A lookup of any operand then reports `out_active`=0.
- R2: When `cfg_full`=1, `cfg_word` is decoded as follows: bits 15:11 are the predicate register, bit 10 is zeroing, bit 9 is invert, bit 8 is the class (1 = floating-point), bits 7:1 are the target register and bit 0 is the packed flag. The resulting lookup returns the predicate register's value as the mask.
- R3: The packed flag is bit 0 of a wide word and appears on `out_packed` for slots 1 to 15. In slot 0, bit 0 is reserved and `out_packed` reads 0.
- R4: When `cfg_full`=0, only `cfg_word[7:0]` is used, and bits 15:8 are ignored. Bit 7 is zeroing, bit 6 is invert, bit 5 is the class, and bits 4:0 are the target register. The predicate register is x(9+slot).
- R5: A narrow word whose low byte is 0x00 empties its slot. The slot's previous target then looks up as unpredicated.
- R6: A lookup matches on both register number and class. Its results appear with `out_valid`=1 on the clock edge after `lk_valid`.
- R7: A lookup with no matching entry returns `out_active`=0, `out_zero`=0, `out_packed`=0 and a mask of ones below `lk_vl`.
- R8: When invert is set, the predicate value is complemented bit by bit before it is truncated to `lk_vl`.
- R9: Predicate register x0 always reads as zero, whatever `rf_rdata` holds. With invert set, x0 gives all ones below `lk_vl`; without invert, it gives an all-zero mask.
- R10: Mask bits at positions `lk_vl` and above are 0. When `lk_vl` is 0, the mask is all zeros. When `lk_vl` is XLEN or more, no bit is cleared by truncation.
- R11: When two slots target the same register and class, the slot written later owns the mapping.
- R12: Rewriting a slot with a new target releases its old target, which then looks up as unpredicated.
- R13: `out_zero` reports the zeroing bit of the matched entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write one entry |
| cfg_full | input | 1 | 1 = wide 16-bit word, 0 = narrow 8-bit word |
| cfg_slot | input | 4 | Entry slot being written |
| cfg_word | input | 16 | Entry encoding |
| lk_valid | input | 1 | Lookup request |
| lk_reg | input | 7 | Operand register number |
| lk_fp | input | 1 | Operand class, 1 = floating-point |
| lk_vl | input | 7 | Element count |
| rf_raddr | output | 5 | Predicate register read address |
| rf_rdata | input | 64 | Predicate register read data, returned in the same cycle |
| out_valid | output | 1 | Lookup result valid |
| out_active | output | 1 | Operand is predicated |
| out_mask | output | 64 | Element mask |
| out_zero | output | 1 | Write zero into masked-off elements |
| out_packed | output | 1 | Packed flag of the matched entry |

## Verification
The hardest state to reach is a reverse map that has gone stale. This happens when one slot is moved to a new target after another slot has already claimed a register, or when a narrow clear removes a slot whose target is still being looked up. The directed sequence reaches it by building mappings, moving one slot to a new register, then letting a second slot take over that same register. Lookups of both the old and new targets follow each step. The x0 case is checked with the bench's register file holding a nonzero value at address 0, so a block that passes the read data through gives a wrong mask.

// File: rtl/predmask_pkg.sv
package predmask_pkg;
   localparam int unsigned PM_KEY_W  = 5;
   localparam int unsigned PM_REG_W  = 7;
   localparam int unsigned PM_SLOT_W = 4;
   localparam int unsigned PM_CMP_BASE = 9;

   typedef struct packed {
      logic                 valid;
      logic [PM_KEY_W-1:0]  key;
      logic                 zero;
      logic                 inv;
      logic                 fp;
      logic [PM_REG_W-1:0]  tgt;
      logic                 packed_f;
   } pm_entry_t;

   typedef struct packed {
      logic                 valid;
      logic [PM_SLOT_W-1:0] slot;
   } pm_rmap_t;
endpackage

// File: rtl/predmask_decode.sv
module predmask_decode
   import predmask_pkg::*;
#(
   parameter int unsigned SLOT_W = 4
) (
   input  logic              full,
   input  logic [SLOT_W-1:0] slot,
   input  logic [15:0]       word,
   output pm_entry_t         ent
);
   always_comb begin
      ent = '0;
      if (full) begin
         ent.valid    = 1'b1;
         ent.key      = word[15:11];
         ent.zero     = word[10];
         ent.inv      = word[9];
         ent.fp       = word[8];
         ent.tgt      = word[7:1];
         ent.packed_f = (slot != '0) && word[0];
      end else begin
         ent.valid    = (word[7:0] != 8'h00);
         ent.key      = PM_KEY_W'(PM_CMP_BASE) + PM_KEY_W'(slot);
         ent.zero     = word[7];
         ent.inv      = word[6];
         ent.fp       = word[5];
         ent.tgt      = PM_REG_W'(word[4:0]);
         ent.packed_f = 1'b0;
      end
   end
endmodule

// File: rtl/predmask_store.sv
module predmask_store
   import predmask_pkg::*;
#(
   parameter int unsigned NUM_ENTRY = 16,
   parameter int unsigned SLOT_W    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SLOT_W-1:0] wr_slot,
   input  pm_entry_t         wr_ent,
   input  logic [PM_REG_W-1:0] rd_reg,
   input  logic              rd_fp,
   output logic              rd_hit,
   output pm_entry_t         rd_ent
);
   localparam int unsigned MAP_N = 2 ** (PM_REG_W + 1);

   pm_entry_t ent_q  [NUM_ENTRY];
   pm_rmap_t  rmap_q [MAP_N];

   pm_entry_t                old_ent;
   logic [PM_REG_W:0]        old_idx;
   logic [PM_REG_W:0]        new_idx;
   logic [PM_REG_W:0]        rd_idx;
   pm_rmap_t                 rd_map;

   assign old_ent = ent_q[wr_slot];
   assign old_idx = {old_ent.fp, old_ent.tgt};
   assign new_idx = {wr_ent.fp, wr_ent.tgt};
   assign rd_idx  = {rd_fp, rd_reg};
   assign rd_map  = rmap_q[rd_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(NUM_ENTRY); i++) ent_q[i] <= '0;
         for (int j = 0; j < int'(MAP_N); j++) rmap_q[j] <= '0;
      end else if (wr_en) begin
         if (old_ent.valid && rmap_q[old_idx].valid &&
             rmap_q[old_idx].slot == PM_SLOT_W'(wr_slot))
            rmap_q[old_idx].valid <= 1'b0;
         if (wr_ent.valid) begin
            rmap_q[new_idx].valid <= 1'b1;
            rmap_q[new_idx].slot  <= PM_SLOT_W'(wr_slot);
         end
         ent_q[wr_slot] <= wr_ent;
      end
   end

   assign rd_hit = rd_map.valid;
   assign rd_ent = ent_q[SLOT_W'(rd_map.slot)];
endmodule

// File: rtl/predmask_shape.sv
module predmask_shape #(
   parameter int unsigned XLEN = 64,
   parameter int unsigned VL_W = 7
) (
   input  logic            hit,
   input  logic            inv,
   input  logic            key_is_x0,
   input  logic [XLEN-1:0] rdata,
   input  logic [VL_W-1:0] vl,
   output logic [XLEN-1:0] mask
);
   logic [XLEN-1:0] src;
   logic [XLEN-1:0] pol;

   assign src = key_is_x0 ? '0 : rdata;
   assign pol = !hit ? '1 : (inv ? ~src : src);

   for (genvar i = 0; i < XLEN; i++) begin : g_elem
      assign mask[i] = pol[i] & (VL_W'(i) < vl);
   end
endmodule

// File: rtl/predmask_table.sv
module predmask_table
   import predmask_pkg::*;
#(
   parameter int unsigned NUM_ENTRY = 16,
   parameter int unsigned XLEN      = 64,
   parameter int unsigned REG_W     = PM_REG_W,
   parameter int unsigned KEY_W     = PM_KEY_W,
   localparam int unsigned SLOT_W   = $clog2(NUM_ENTRY),
   localparam int unsigned VL_W     = $clog2(XLEN + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_full,
   input  logic [SLOT_W-1:0] cfg_slot,
   input  logic [15:0]       cfg_word,
   input  logic              lk_valid,
   input  logic [REG_W-1:0]  lk_reg,
   input  logic              lk_fp,
   input  logic [VL_W-1:0]   lk_vl,
   output logic [KEY_W-1:0]  rf_raddr,
   input  logic [XLEN-1:0]   rf_rdata,
   output logic              out_valid,
   output logic              out_active,
   output logic [XLEN-1:0]   out_mask,
   output logic              out_zero,
   output logic              out_packed
);
   if (REG_W != PM_REG_W) begin : g_chk_reg
      $error("REG_W must match the package register width");
   end
   if (KEY_W != PM_KEY_W) begin : g_chk_key
      $error("KEY_W must match the package key width");
   end
   if (SLOT_W > PM_SLOT_W || NUM_ENTRY < 2) begin : g_chk_slot
      $error("NUM_ENTRY out of range for the slot field");
   end
   if (PM_CMP_BASE + NUM_ENTRY > 2 ** KEY_W) begin : g_chk_cmp
      $error("narrow entries would name a register beyond the file");
   end

   pm_entry_t       dec_ent;
   pm_entry_t       sel_ent;
   logic            lk_hit;
   logic            sel_inv;
   logic [XLEN-1:0] mask_d;

   predmask_decode #(.SLOT_W(SLOT_W)) u_dec (
      .full (cfg_full),
      .slot (cfg_slot),
      .word (cfg_word),
      .ent  (dec_ent)
   );

   predmask_store #(.NUM_ENTRY(NUM_ENTRY), .SLOT_W(SLOT_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we),
      .wr_slot (cfg_slot),
      .wr_ent  (dec_ent),
      .rd_reg  (lk_reg),
      .rd_fp   (lk_fp),
      .rd_hit  (lk_hit),
      .rd_ent  (sel_ent)
   );

   assign sel_inv  = sel_ent.inv;
   assign rf_raddr = lk_hit ? sel_ent.key : '0;

   predmask_shape #(.XLEN(XLEN), .VL_W(VL_W)) u_shape (
      .hit       (lk_hit),
      .inv       (sel_inv),
      .key_is_x0 (rf_raddr == '0),
      .rdata     (rf_rdata),
      .vl        (lk_vl),
      .mask      (mask_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_active <= 1'b0;
         out_mask   <= '0;
         out_zero   <= 1'b0;
         out_packed <= 1'b0;
      end else begin
         out_valid <= lk_valid;
         if (lk_valid) begin
            out_active <= lk_hit;
            out_mask   <= mask_d;
            out_zero   <= lk_hit && sel_ent.zero;
            out_packed <= lk_hit && sel_ent.packed_f;
         end
      end
   end
endmodule

// File: rtl/predmask_table_chk.sv
module predmask_table_chk #(
   parameter int unsigned XLEN  = 64,
   parameter int unsigned VL_W  = 7,
   parameter int unsigned KEY_W = 5
) (
   input logic            clk,
   input logic            rst_n,
   input logic            lk_valid,
   input logic [VL_W-1:0] lk_vl,
   input logic            lk_hit,
   input logic            sel_inv,
   input logic [KEY_W-1:0] rf_raddr,
   input logic            out_valid,
   input logic            out_active,
   input logic [XLEN-1:0] out_mask,
   input logic            out_zero,
   input logic            out_packed
);
   function automatic logic [XLEN-1:0] below(input logic [VL_W-1:0] n);
      logic [XLEN-1:0] m;
      for (int i = 0; i < int'(XLEN); i++) m[i] = (i < int'(n));
      return m;
   endfunction

   // R6: result appears one edge after the request
   assert_valid_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> out_valid);

   // R1: no result without a request
   assert_no_spurious_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> !out_valid);

   // R10: nothing set at or above the element count
   assert_vl_trunc_R10: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> ((out_mask & ~below($past(lk_vl))) == '0));

   // R7: a miss gives ones below the count and no controls
   assert_miss_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid && !lk_hit |=> (!out_active && !out_zero && !out_packed &&
                               out_mask == below($past(lk_vl))));

   // R9: x0 with invert gives every element
   assert_x0_inv_R9: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid && lk_hit && sel_inv && rf_raddr == '0 |=>
         out_mask == below($past(lk_vl)));
endmodule

bind predmask_table predmask_table_chk #(.XLEN(XLEN), .VL_W(VL_W), .KEY_W(KEY_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .lk_valid   (lk_valid),
   .lk_vl      (lk_vl),
   .lk_hit     (lk_hit),
   .sel_inv    (sel_inv),
   .rf_raddr   (rf_raddr),
   .out_valid  (out_valid),
   .out_active (out_active),
   .out_mask   (out_mask),
   .out_zero   (out_zero),
   .out_packed (out_packed)
);

// File: tb/predmask_table_tb.sv
module predmask_table_tb;
   localparam int XL = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic        cfg_full = 1'b0;
   logic [3:0]  cfg_slot = '0;
   logic [15:0] cfg_word = '0;
   logic        lk_valid = 1'b0;
   logic [6:0]  lk_reg = '0;
   logic        lk_fp = 1'b0;
   logic [6:0]  lk_vl = '0;
   logic [4:0]  rf_raddr;
   logic [XL-1:0] rf_rdata;
   logic        out_valid, out_active, out_zero, out_packed;
   logic [XL-1:0] out_mask;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [XL-1:0] regs [32];

   always #5 clk = ~clk;

   assign rf_rdata = regs[rf_raddr];

   predmask_table u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_full(cfg_full),
      .cfg_slot(cfg_slot), .cfg_word(cfg_word), .lk_valid(lk_valid),
      .lk_reg(lk_reg), .lk_fp(lk_fp), .lk_vl(lk_vl), .rf_raddr(rf_raddr),
      .rf_rdata(rf_rdata), .out_valid(out_valid), .out_active(out_active),
      .out_mask(out_mask), .out_zero(out_zero), .out_packed(out_packed)
   );

   function automatic logic [XL-1:0] pat(input int i);
      return 64'hA5C3_1E7F_0F96_3C5A ^ {8{8'(i)}};
   endfunction

   function automatic logic [XL-1:0] low(input int n);
      logic [XL-1:0] m;
      for (int i = 0; i < XL; i++) m[i] = (i < n);
      return m;
   endfunction

   function automatic logic [15:0] wide(input int key, input bit z, input bit inv,
                                        input bit fp, input int tgt, input bit pk);
      return {5'(key), z, inv, fp, 7'(tgt), pk};
   endfunction

   task automatic check(input string req, input string what,
                        input logic [XL-1:0] act, input logic [XL-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic write_cfg(input bit full, input int slot, input logic [15:0] w);
      @(negedge clk);
      cfg_we = 1'b1; cfg_full = full; cfg_slot = 4'(slot); cfg_word = w;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic lookup(input string req, input int r, input bit fp, input int vl,
                         input bit e_act, input logic [XL-1:0] e_mask,
                         input bit e_zero, input bit e_pk);
      @(negedge clk);
      lk_valid = 1'b1; lk_reg = 7'(r); lk_fp = fp; lk_vl = 7'(vl);
      @(negedge clk);
      lk_valid = 1'b0;
      check(req, "valid",  64'(out_valid),  64'd1);
      check(req, "active", 64'(out_active), 64'(e_act));
      check(req, "mask",   out_mask,        e_mask);
      check(req, "zero",   64'(out_zero),   64'(e_zero));
      check(req, "packed", 64'(out_packed), 64'(e_pk));
   endtask

   task automatic t_reset;
      check("R1", "valid after reset", 64'(out_valid), 64'd0);
      lookup("R1_R7", 10, 1'b0, 64, 1'b0, low(64), 1'b0, 1'b0);
      lookup("R7", 10, 1'b0, 13, 1'b0, low(13), 1'b0, 1'b0);
   endtask

   task automatic t_wide;
      write_cfg(1'b1, 1, wide(5, 1'b1, 1'b0, 1'b0, 10, 1'b1));
      lookup("R2_R13_R3", 10, 1'b0, 64, 1'b1, pat(5), 1'b1, 1'b1);
      lookup("R6", 10, 1'b1, 64, 1'b0, low(64), 1'b0, 1'b0);
   endtask

   task automatic t_slot0;
      write_cfg(1'b1, 0, wide(6, 1'b0, 1'b0, 1'b1, 20, 1'b1));
      lookup("R3", 20, 1'b1, 64, 1'b1, pat(6), 1'b0, 1'b0);
   endtask

   task automatic t_invert;
      write_cfg(1'b1, 2, wide(7, 1'b0, 1'b1, 1'b0, 3, 1'b0));
      lookup("R8_R10", 3, 1'b0, 20, 1'b1, ~pat(7) & low(20), 1'b0, 1'b0);
      lookup("R10", 3, 1'b0, 0, 1'b1, '0, 1'b0, 1'b0);
   endtask

   task automatic t_x0;
      write_cfg(1'b1, 6, wide(0, 1'b0, 1'b1, 1'b0, 30, 1'b0));
      lookup("R9", 30, 1'b0, 64, 1'b1, '1, 1'b0, 1'b0);
      lookup("R9_R10", 30, 1'b0, 40, 1'b1, low(40), 1'b0, 1'b0);
      write_cfg(1'b1, 7, wide(0, 1'b0, 1'b0, 1'b1, 31, 1'b0));
      lookup("R9", 31, 1'b1, 64, 1'b1, '0, 1'b0, 1'b0);
   endtask

   task automatic t_narrow;
      write_cfg(1'b0, 3, {8'hFF, 8'b1100_0111});
      lookup("R4", 7, 1'b0, 64, 1'b1, ~pat(12), 1'b1, 1'b0);
      write_cfg(1'b0, 3, {8'hFF, 8'h00});
      lookup("R5", 7, 1'b0, 64, 1'b0, low(64), 1'b0, 1'b0);
   endtask

   task automatic t_retarget;
      write_cfg(1'b1, 1, wide(5, 1'b1, 1'b0, 1'b0, 11, 1'b1));
      lookup("R12", 10, 1'b0, 64, 1'b0, low(64), 1'b0, 1'b0);
      lookup("R12", 11, 1'b0, 64, 1'b1, pat(5), 1'b1, 1'b1);
   endtask

   task automatic t_override;
      write_cfg(1'b1, 5, wide(8, 1'b0, 1'b0, 1'b0, 11, 1'b0));
      lookup("R11", 11, 1'b0, 64, 1'b1, pat(8), 1'b0, 1'b0);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      for (int i = 0; i < 32; i++) regs[i] = pat(i);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_wide();
      t_slot0();
      t_invert();
      t_x0();
      t_narrow();
      t_retarget();
      t_override();
      repeat (2) @(negedge clk);
      finish_run();
   end

   initial begin
      #200000;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end
endmodule